// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a 16-bit record of why the chip last came out of reset or last entered a low-power mode. Each possible cause arrives as a one-cycle pulse from the logic that detects it. The block turns that pulse into a sticky flag at a fixed bit position. Power events wipe most of the older history when they record themselves. Software reads the register after start-up to find the cause, and it can rewrite any flag through a simple write port.

Every flag has its own set of events that raise it and its own set of events that lower it. When a raise and a lower reach the same flag in the same cycle, the raise wins. Hardware events also override a software write that lands in the same cycle. Bit positions that hold no flag always read as zero.

Top module: `reset_cause_reg`

## Requirements
- R1: While the asynchronous reset `rstN` is low, and in the first cycle after it is released, the register reads 0x0003 (power-on and brown-out flags set). Unused bit positions (13:10, 8, 5) always read 0.
- R2: One clock edge after a pulse, the event's flag reads 1. The flags and their bits are: trap conflict at bit 15, configuration mismatch at bit 9, external pin at bit 7, software reset at bit 6, watchdog timeout at bit 4, sleep entry at bit 3 and idle entry at bit 2.
- R3: Bit 14 (illegal operation) is set by an illegal opcode, by use of an uninitialised register as a pointer, or by a security violation.
- R4: A power-on pulse sets bits 0 and 1. A brown-out pulse sets bit 1 and leaves bit 0 unchanged.
- R5: A power-on or brown-out pulse clears bits 15, 14, 9, 7, 6, 4, 3 and 2.
- R6: The watchdog timeout flag (bit 4) is cleared by a watchdog-clear, sleep entry or idle entry pulse. No other flag is cleared by these pulses.
- R7: A write with `wrEn` high loads `wrData` into every implemented bit one edge later. Unused bits ignore the written value.
- R8: When one flag gets a set event and a clear event in the same cycle, the flag ends up set.
- R9: A hardware event in the same cycle as a write overrides the written value for the bits that the event sets or clears. The write still takes effect on all other bits.
- R10: With no event and no write, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, loads the power-on value |
| evPowerOn | input | 1 | Power-on pulse |
| evBrownOut | input | 1 | Brown-out pulse |
| evTrapConflict | input | 1 | Trap conflict pulse |
| evIllegalOp | input | 1 | Illegal opcode pulse |
| evUninitReg | input | 1 | Uninitialised register used as a pointer |
| evSecurity | input | 1 | Branch or vector load into a protected region |
| evCfgMismatch | input | 1 | Configuration mismatch pulse |
| evExtPin | input | 1 | External reset pin pulse |
| evSwReset | input | 1 | Software reset instruction pulse |
| evWdtTimeout | input | 1 | Watchdog timeout pulse |
| evSleep | input | 1 | Sleep entry pulse |
| evIdle | input | 1 | Idle entry pulse |
| evWdtClear | input | 1 | Watchdog clear instruction pulse |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 16 | Software write value |
| rdData | output | 16 | Current flag register |

## Verification
Every result is due exactly one clock edge after its stimulus, because the read port comes straight from the flag register. The bench drives the event pulses and write values on the falling edge and removes them on the next falling edge. It compares `rdData` at that second falling edge, half a cycle after the rising edge that captured the change. The hold check samples on several later falling edges to confirm the value stays put between stimuli.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;
  localparam int REG_W       = 16;
  localparam int BIT_TRAP    = 15;
  localparam int BIT_ILLEGAL = 14;
  localparam int BIT_CFG     = 9;
  localparam int BIT_EXT     = 7;
  localparam int BIT_SWR     = 6;
  localparam int BIT_WDTO    = 4;
  localparam int BIT_SLEEP   = 3;
  localparam int BIT_IDLE    = 2;
  localparam int BIT_BOR     = 1;
  localparam int BIT_POR     = 0;

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << BIT_TRAP) | (REG_W'(1) << BIT_ILLEGAL) |
      (REG_W'(1) << BIT_CFG)  | (REG_W'(1) << BIT_EXT) |
      (REG_W'(1) << BIT_SWR)  | (REG_W'(1) << BIT_WDTO) |
      (REG_W'(1) << BIT_SLEEP)| (REG_W'(1) << BIT_IDLE) |
      (REG_W'(1) << BIT_BOR)  | (REG_W'(1) << BIT_POR);

  localparam logic [REG_W-1:0] POWER_KEEP = (REG_W'(1) << BIT_BOR) | (REG_W'(1) << BIT_POR);
  localparam logic [REG_W-1:0] POWER_CLR  = IMPL_MASK & ~POWER_KEEP;
  localparam logic [REG_W-1:0] RESET_VAL  = POWER_KEEP;

  typedef struct packed {
    logic [REG_W-1:0] setVec;
    logic [REG_W-1:0] clrVec;
    logic             wrLoad;
  } rcStrobes_t;
endpackage

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import reset_cause_pkg::*;
(
  input  logic       evPowerOn,
  input  logic       evBrownOut,
  input  logic       evTrapConflict,
  input  logic       evIllegalOp,
  input  logic       evUninitReg,
  input  logic       evSecurity,
  input  logic       evCfgMismatch,
  input  logic       evExtPin,
  input  logic       evSwReset,
  input  logic       evWdtTimeout,
  input  logic       evSleep,
  input  logic       evIdle,
  input  logic       evWdtClear,
  input  logic       wrEn,
  output rcStrobes_t strobes
);
  logic powerEvt;

  always_comb begin
    powerEvt = evPowerOn | evBrownOut;

    strobes.setVec              = '0;
    strobes.setVec[BIT_TRAP]    = evTrapConflict;
    strobes.setVec[BIT_ILLEGAL] = evIllegalOp | evUninitReg | evSecurity;
    strobes.setVec[BIT_CFG]     = evCfgMismatch;
    strobes.setVec[BIT_EXT]     = evExtPin;
    strobes.setVec[BIT_SWR]     = evSwReset;
    strobes.setVec[BIT_WDTO]    = evWdtTimeout;
    strobes.setVec[BIT_SLEEP]   = evSleep;
    strobes.setVec[BIT_IDLE]    = evIdle;
    strobes.setVec[BIT_BOR]     = powerEvt;
    strobes.setVec[BIT_POR]     = evPowerOn;

    strobes.clrVec              = powerEvt ? POWER_CLR : '0;
    strobes.clrVec[BIT_WDTO]    = powerEvt | evSleep | evIdle | evWdtClear;

    strobes.wrLoad              = wrEn;
  end
endmodule

// File: rtl/reset_cause_dp.sv
module reset_cause_dp
  import reset_cause_pkg::*;
#(
  parameter int               W        = REG_W,
  parameter logic [W-1:0]     MASK     = IMPL_MASK,
  parameter logic [W-1:0]     INIT_VAL = RESET_VAL
) (
  input  logic         clk,
  input  logic         rstN,
  input  rcStrobes_t   strobes,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] flags
);
  logic [W-1:0] baseVal;
  logic [W-1:0] nextVal;
  logic         pastValid;

  always_comb begin
    baseVal = strobes.wrLoad ? wrData : flags;
    nextVal = ((baseVal & ~strobes.clrVec) | strobes.setVec) & MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags     <= INIT_VAL;
      pastValid <= 1'b0;
    end else begin
      flags     <= nextVal;
      pastValid <= 1'b1;
    end
  end

  // R8 / R9: every set strobe is visible in the register one edge later
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((flags & $past(strobes.setVec)) == $past(strobes.setVec)));

  // R5 / R6: a clear strobe without a matching set leaves the bit at zero
  assert_clear_applied_R5: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((flags & $past(strobes.clrVec) & ~$past(strobes.setVec)) == '0));

  // R1 / R7: unused bit positions never hold a one
  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~MASK) == '0);
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import reset_cause_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             evPowerOn,
  input  logic             evBrownOut,
  input  logic             evTrapConflict,
  input  logic             evIllegalOp,
  input  logic             evUninitReg,
  input  logic             evSecurity,
  input  logic             evCfgMismatch,
  input  logic             evExtPin,
  input  logic             evSwReset,
  input  logic             evWdtTimeout,
  input  logic             evSleep,
  input  logic             evIdle,
  input  logic             evWdtClear,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData
);
  rcStrobes_t strobes;
  logic       anyEvent;
  logic       pastValid;

  reset_cause_ctrl u_ctrl (
    .evPowerOn     (evPowerOn),
    .evBrownOut    (evBrownOut),
    .evTrapConflict(evTrapConflict),
    .evIllegalOp   (evIllegalOp),
    .evUninitReg   (evUninitReg),
    .evSecurity    (evSecurity),
    .evCfgMismatch (evCfgMismatch),
    .evExtPin      (evExtPin),
    .evSwReset     (evSwReset),
    .evWdtTimeout  (evWdtTimeout),
    .evSleep       (evSleep),
    .evIdle        (evIdle),
    .evWdtClear    (evWdtClear),
    .wrEn          (wrEn),
    .strobes       (strobes)
  );

  reset_cause_dp #(
    .W       (REG_W),
    .MASK    (IMPL_MASK),
    .INIT_VAL(RESET_VAL)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (wrData),
    .flags  (rdData)
  );

  assign anyEvent = evPowerOn | evBrownOut | evTrapConflict | evIllegalOp | evUninitReg |
                    evSecurity | evCfgMismatch | evExtPin | evSwReset | evWdtTimeout |
                    evSleep | evIdle | evWdtClear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R4: power-on raises both power flags
  assert_por_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(evPowerOn)) |-> (rdData[BIT_POR] && rdData[BIT_BOR]));

  // R4: brown-out alone leaves the power-on flag untouched
  assert_bor_keeps_por_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(evBrownOut && !evPowerOn && !wrEn)) |->
      (rdData[BIT_BOR] && rdData[BIT_POR] == $past(rdData[BIT_POR])));

  // R6: watchdog clear without a fresh timeout drops the timeout flag
  assert_wdt_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(evWdtClear && !evWdtTimeout)) |-> !rdData[BIT_WDTO]);

  // R10: quiet cycles keep the register
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!anyEvent && !wrEn)) |-> $stable(rdData));
endmodule

// File: tb/reset_cause_reg_tb.sv
`timescale 1ns/1ps
module reset_cause_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] ev = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  int          checks = 0;
  int          errors = 0;

  // ev index: 0 por,1 bor,2 trap,3 illegal,4 uninit,5 security,6 cfg,7 ext,
  //           8 sw,9 wdt,10 sleep,11 idle,12 wdtclr
  localparam logic [15:0] ALL_ONES = 16'hC2DF;

  always #2.5 clk = ~clk;

  reset_cause_reg u_dut (
    .clk(clk), .rstN(rstN),
    .evPowerOn(ev[0]), .evBrownOut(ev[1]), .evTrapConflict(ev[2]),
    .evIllegalOp(ev[3]), .evUninitReg(ev[4]), .evSecurity(ev[5]),
    .evCfgMismatch(ev[6]), .evExtPin(ev[7]), .evSwReset(ev[8]),
    .evWdtTimeout(ev[9]), .evSleep(ev[10]), .evIdle(ev[11]), .evWdtClear(ev[12]),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: rdData=%h expected=%h", req, rdData, exp);
    end
  endtask

  // drive for one cycle on the falling edge, result due after the next rising edge
  task automatic apply(input logic [12:0] e, input logic w, input logic [15:0] d);
    ev = e; wrEn = w; wrData = d;
    @(negedge clk);
    ev = '0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic load(input logic [15:0] d);
    apply('0, 1'b1, d);
  endtask

  task automatic t_reset;
    check("R1", 16'h0003);
    @(negedge clk);
    check("R1", 16'h0003);
  endtask

  task automatic t_write;
    load(16'h0000); check("R7", 16'h0000);
    load(16'hFFFF); check("R7", ALL_ONES);
    load(16'h3D20); check("R7", 16'h0000);
    load(16'h4281); check("R7", 16'h4281);
  endtask

  task automatic t_each_event;
    logic [15:0] expv [13] = '{16'h0003, 16'h0002, 16'h8000, 16'h4000, 16'h4000,
                               16'h4000, 16'h0200, 16'h0080, 16'h0040, 16'h0010,
                               16'h0008, 16'h0004, 16'h0000};
    string tags [13] = '{"R4", "R4", "R2", "R3", "R3", "R3", "R2", "R2", "R2",
                         "R2", "R2", "R2", "R6"};
    for (int i = 0; i < 13; i++) begin
      load(16'h0000);
      apply(13'(1) << i, 1'b0, '0);
      check(tags[i], expv[i]);
    end
  endtask

  task automatic t_power_clear;
    load(16'hFFFF); apply(13'h0002, 1'b0, '0); check("R5", 16'h0003);
    load(16'hC2DC); apply(13'h0002, 1'b0, '0); check("R4", 16'h0002);
    load(16'hC2DC); apply(13'h0001, 1'b0, '0); check("R5", 16'h0003);
  endtask

  task automatic t_wdt_clear;
    load(16'hFFFF); apply(13'h1000, 1'b0, '0); check("R6", 16'hC2CF);
    load(16'h0010); apply(13'h0400, 1'b0, '0); check("R6", 16'h0008);
    load(16'h0010); apply(13'h0800, 1'b0, '0); check("R6", 16'h0004);
  endtask

  task automatic t_conflict;
    load(16'h0000); apply(13'h1200, 1'b0, '0); check("R8", 16'h0010);
    load(16'hFFFF); apply(13'h0006, 1'b0, '0); check("R8", 16'h8003);
    load(16'h0000); apply(13'h0600, 1'b0, '0); check("R8", 16'h0018);
  endtask

  task automatic t_hw_over_sw;
    load(16'h0000); apply(13'h0004, 1'b1, 16'h0000); check("R9", 16'h8000);
    load(16'h0000); apply(13'h1000, 1'b1, 16'h0010); check("R9", 16'h0000);
    load(16'h0000); apply(13'h0080, 1'b1, 16'h0200); check("R9", 16'h0280);
    load(16'h0000); apply(13'h0002, 1'b1, 16'h8080); check("R9", 16'h0002);
  endtask

  task automatic t_hold;
    load(16'h4281);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R10", 16'h4281);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_write();
    t_each_event();
    t_power_clear();
    t_wdt_clear();
    t_conflict();
    t_hw_over_sw();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule